// File: doc/BRIEF.md
# Fan Duty Slew Limiter

This block sits between the stage that computes a fan's target duty and the PWM generator. It serves two independent channels, A and B. When a channel's ramping is switched off, its output duty follows the target on the next clock. When ramping is switched on, the output moves toward the target once per time slot. Each move is a programmable step, so a fan changes speed gradually and audibly smoothly rather than jumping.

One 8-bit control register sets up both channels through a write strobe and data byte, and it can always be read back. A lock request freezes the register until reset. For each channel the block also drives a flag that tells the spin-up logic to stand down while that channel is ramping. The time slot comes from a prescaler. Its default gives about 0.2 s at a 100 MHz clock, so a climb from 33% to 100% duty takes about 35 s at the slowest code and under a second at the fastest.

Top module: `fan_slew_top`

## Requirements
- R1: After reset the control register reads 0x00, both duties are 0, the lock flag is 0 and both spin-up inhibit flags are 0.
- R2: Register layout: bits 2:0 are the channel-A rate code, bit 3 is the channel-A ramp enable, bits 6:4 are the channel-B rate code and bit 7 is the channel-B ramp enable. An unlocked write appears on the read port one cycle after the strobe.
- R3: Rate codes 0 to 7 give duty steps of 1, 2, 3, 5, 8, 12, 24 and 48 per time slot.
- R4: With its enable bit 0, a channel's duty equals that channel's target as sampled on the previous clock edge.
- R5: With its enable bit 1, a channel's duty changes only on slot-tick cycles. On such a cycle it moves toward the target by its step, both upward and downward.
- R6: When the remaining distance is no larger than the step, the duty lands exactly on the target and then holds there, with no overshoot.
- R7: If the target changes during a ramp, the next step starts from the present duty and heads toward the new target.
- R8: Asserting the lock request sets a lock flag that stays set until reset. A write in the same cycle as the lock request, or in any later cycle, leaves the register unchanged.
- R9: Each channel's spin-up inhibit output equals that channel's ramp enable bit.
- R10: A slot tick occurs once every SLOT_CYCLES clocks. A climb from 84 to 255 takes ceil(171/step) slots at each rate code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| lock_req | input | 1 | Request to lock the register |
| cfg_locked | output | 1 | Lock flag, sticky until reset |
| target_a | input | 8 | Channel A target duty |
| target_b | input | 8 | Channel B target duty |
| duty_a | output | 8 | Channel A limited duty |
| duty_b | output | 8 | Channel B limited duty |
| spinup_off_a | output | 1 | Channel A spin-up inhibit |
| spinup_off_b | output | 1 | Channel B spin-up inhibit |

## Verification
Each result is due a fixed number of cycles after its stimulus:
- A register write or lock request shows on the read port and the lock flag one cycle later.
- A follow-mode target shows on the duty output one cycle later.
- A ramp step shows one cycle after the clock edge on which the slot counter hits its last count.

The bench steps a behavioural model at each rising edge from the same inputs the design sees. It drives inputs and compares every output at the falling edge, so each comparison falls exactly where that latency puts the result. Separate targeted checks measure slot counts for every rate code and test that writes are refused after locking.

// File: rtl/fan_slew_pkg.sv
package fan_slew_pkg;

    localparam int DUTY_W = 8;
    localparam int NUM_CH = 2;

    typedef logic [DUTY_W-1:0] duty_t;

    typedef enum logic [2:0] {
        RATE_1  = 3'd0,
        RATE_2  = 3'd1,
        RATE_3  = 3'd2,
        RATE_5  = 3'd3,
        RATE_8  = 3'd4,
        RATE_12 = 3'd5,
        RATE_24 = 3'd6,
        RATE_48 = 3'd7
    } rate_e;

    typedef struct packed {
        logic  en;
        rate_e rate;
    } chan_cfg_t;

    // index 1 is channel B (bits 7:4), index 0 is channel A (bits 3:0)
    typedef chan_cfg_t [NUM_CH-1:0] ctrl_reg_t;

    function automatic duty_t step_for(rate_e r);
        case (r)
            RATE_1:  return duty_t'(1);
            RATE_2:  return duty_t'(2);
            RATE_3:  return duty_t'(3);
            RATE_5:  return duty_t'(5);
            RATE_8:  return duty_t'(8);
            RATE_12: return duty_t'(12);
            RATE_24: return duty_t'(24);
            default: return duty_t'(48);
        endcase
    endfunction

    function automatic duty_t approach(duty_t cur, duty_t tgt, duty_t step);
        duty_t gap;
        if (tgt > cur) begin
            gap = tgt - cur;
            return (gap <= step) ? tgt : duty_t'(cur + step);
        end else if (tgt < cur) begin
            gap = cur - tgt;
            return (gap <= step) ? tgt : duty_t'(cur - step);
        end
        return cur;
    endfunction

endpackage

// File: rtl/fan_slew_cfg.sv
module fan_slew_cfg
    import fan_slew_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  logic [7:0] wdata,
    input  logic      lock_req,
    output ctrl_reg_t cfg,
    output logic      locked
);

    ctrl_reg_t cfg_q;
    logic      locked_q;
    logic      wr_ok;

    assign wr_ok = wr && !locked_q && !lock_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            locked_q <= 1'b0;
        end else begin
            if (wr_ok)
                cfg_q <= ctrl_reg_t'(wdata);
            if (lock_req)
                locked_q <= 1'b1;
        end
    end

    assign cfg    = cfg_q;
    assign locked = locked_q;

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> locked_q);
    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        (locked_q || lock_req) |=> $stable(cfg_q));
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr && !locked_q && !lock_req) |=> (cfg_q == ctrl_reg_t'($past(wdata))));

endmodule

// File: rtl/fan_slew_timer.sv
module fan_slew_timer #(
    parameter int SLOT_CYCLES = 20_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    generate
        if (SLOT_CYCLES > 1) begin : g_spacing
            a_r10_tick_spacing: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/fan_slew_chan.sv
module fan_slew_chan
    import fan_slew_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg,
    input  logic      tick,
    input  duty_t     target,
    output duty_t     duty,
    output logic      spin_off
);

    duty_t duty_q;
    duty_t step;

    assign step = step_for(cfg.rate);

    always_ff @(posedge clk) begin
        if (rst)
            duty_q <= '0;
        else if (!cfg.en)
            duty_q <= target;
        else if (tick)
            duty_q <= approach(duty_q, target, step);
    end

    assign duty     = duty_q;
    assign spin_off = cfg.en;

    a_r4_follow: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> (duty_q == $past(target)));
    a_r5_hold_between_slots: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && !tick) |=> (duty_q == $past(duty_q)));
    a_r6_no_overshoot_up: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && tick && duty_q <= target) |=>
            (duty_q <= $past(target) && duty_q >= $past(duty_q)));
    a_r6_no_overshoot_down: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && tick && duty_q >= target) |=>
            (duty_q >= $past(target) && duty_q <= $past(duty_q)));

endmodule

// File: rtl/fan_slew_top.sv
module fan_slew_top
    import fan_slew_pkg::*;
#(
    parameter int SLOT_CYCLES = 20_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       lock_req,
    output logic       cfg_locked,
    input  logic [7:0] target_a,
    input  logic [7:0] target_b,
    output logic [7:0] duty_a,
    output logic [7:0] duty_b,
    output logic       spinup_off_a,
    output logic       spinup_off_b
);

    ctrl_reg_t cfg;
    logic      tick;
    duty_t     tgt  [NUM_CH];
    duty_t     duty [NUM_CH];
    logic      spin [NUM_CH];

    fan_slew_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .wdata    (cfg_wdata),
        .lock_req (lock_req),
        .cfg      (cfg),
        .locked   (cfg_locked)
    );

    fan_slew_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign tgt[0] = target_a;
    assign tgt[1] = target_b;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            fan_slew_chan u_chan (
                .clk      (clk),
                .rst      (rst),
                .cfg      (cfg[ch]),
                .tick     (tick),
                .target   (tgt[ch]),
                .duty     (duty[ch]),
                .spin_off (spin[ch])
            );
        end
    endgenerate

    assign cfg_rdata    = 8'(cfg);
    assign duty_a       = duty[0];
    assign duty_b       = duty[1];
    assign spinup_off_a = spin[0];
    assign spinup_off_b = spin[1];

endmodule

// File: tb/fan_slew_top_tb_top.sv
`timescale 1ns/1ps
module fan_slew_top_tb_top;

    localparam int SLOT = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       lock_req = 1'b0;
    logic       cfg_locked;
    logic [7:0] target_a = 8'd0;
    logic [7:0] target_b = 8'd0;
    logic [7:0] duty_a, duty_b;
    logic       spinup_off_a, spinup_off_b;

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural reference state
    int m_cfg  = 0;
    int m_lock = 0;
    int m_cnt  = 0;
    int m_duty [2] = '{0, 0};
    bit started = 0;

    always #4 clk = ~clk;

    fan_slew_top #(.SLOT_CYCLES(SLOT)) dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .lock_req(lock_req), .cfg_locked(cfg_locked),
        .target_a(target_a), .target_b(target_b), .duty_a(duty_a), .duty_b(duty_b),
        .spinup_off_a(spinup_off_a), .spinup_off_b(spinup_off_b)
    );

    function automatic int step_of(int code);
        int tbl [8] = '{1, 2, 3, 5, 8, 12, 24, 48};
        return tbl[code & 7];
    endfunction

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cfg = 0; m_lock = 0; m_cnt = 0;
            m_duty[0] = 0; m_duty[1] = 0;
        end else begin
            bit tk;
            tk = (m_cnt == SLOT - 1);
            for (int ch = 0; ch < 2; ch++) begin
                int en, st, tg, d;
                en = (m_cfg >> (ch * 4 + 3)) & 1;
                st = step_of(m_cfg >> (ch * 4));
                tg = (ch == 0) ? int'(target_a) : int'(target_b);
                d  = m_duty[ch];
                if (en == 0) d = tg;
                else if (tk) begin
                    if (tg > d) d = (tg - d <= st) ? tg : d + st;
                    else if (tg < d) d = (d - tg <= st) ? tg : d - st;
                end
                m_duty[ch] = d;
            end
            if (cfg_wr && m_lock == 0 && !lock_req) m_cfg = int'(cfg_wdata);
            if (lock_req) m_lock = 1;
            m_cnt = tk ? 0 : m_cnt + 1;
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started) begin
            check("R1 R2 R8 cfg_rdata", int'(cfg_rdata), m_cfg);
            check("R1 R8 cfg_locked", int'(cfg_locked), m_lock);
            check("R3 R4 R5 R6 R7 duty_a", int'(duty_a), m_duty[0]);
            check("R3 R4 R5 R6 R7 duty_b", int'(duty_b), m_duty[1]);
            check("R9 spinup_off_a", int'(spinup_off_a), (m_cfg >> 3) & 1);
            check("R9 spinup_off_b", int'(spinup_off_b), (m_cfg >> 7) & 1);
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cycles(3);
        rst = 1'b0;
        // R1 reset state
        check("R1 reset rdata", int'(cfg_rdata), 0);
        check("R1 reset duty_a", int'(duty_a), 0);
        check("R1 reset lock", int'(cfg_locked), 0);
        check("R1 reset spinup_off_b", int'(spinup_off_b), 0);

        // R4 follow mode
        target_a = 8'd200; target_b = 8'd17;
        cycles(1);
        check("R4 follow a", int'(duty_a), 200);
        target_a = 8'd3;
        cycles(1);
        check("R4 follow a down", int'(duty_a), 3);

        // R5 R7: ramp both channels, both directions, mid-ramp retarget
        write_cfg(8'hEB); // B: en, code 6 (24); A: en, code 3 (5)
        check("R2 readback", int'(cfg_rdata), 8'hEB);
        target_a = 8'd250; target_b = 8'd250;
        cycles(SLOT * 6);
        target_a = 8'd10;   // R7 reverse mid-ramp
        cycles(SLOT * 12);
        target_b = 8'd0;
        cycles(SLOT * 14);
        check("R6 settle a", int'(duty_a), 10);
        check("R6 settle b", int'(duty_b), 0);

        // R10 / R3 slot counts for a 84 -> 255 climb at each code
        for (int code = 0; code < 8; code++) begin
            int changes;
            int prev;
            int expct;
            write_cfg(8'h00);
            target_a = 8'd84;
            cycles(2);
            write_cfg(8'(8 | code));
            target_a = 8'd255;
            changes = 0;
            prev = int'(duty_a);
            for (int k = 0; k < SLOT * 200 && duty_a != 8'd255; k++) begin
                cycles(1);
                if (int'(duty_a) != prev) changes++;
                prev = int'(duty_a);
            end
            expct = (171 + step_of(code) - 1) / step_of(code);
            check($sformatf("R10 slots code %0d", code), changes, expct);
            check("R6 lands at 255", int'(duty_a), 255);
        end

        // R8 lock, write in the same cycle ignored, later writes ignored
        write_cfg(8'h5A);
        @(negedge clk);
        lock_req = 1'b1; cfg_wr = 1'b1; cfg_wdata = 8'hFF;
        @(negedge clk);
        lock_req = 1'b0; cfg_wr = 1'b0;
        check("R8 same-cycle write ignored", int'(cfg_rdata), 8'h5A);
        check("R8 locked", int'(cfg_locked), 1);
        write_cfg(8'h00);
        check("R8 later write ignored", int'(cfg_rdata), 8'h5A);
        target_b = 8'd77;
        cycles(SLOT * 3);
        check("R8 lock sticky", int'(cfg_locked), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule